// File: doc/BRIEF.md
# Guarded Trap Table Base Register

This block holds the start address of a processor's trap and vector table. It is reached through a simple single-cycle peripheral bus. The bus has a byte address, 32-bit write data, four byte enables, a write strobe, a read strobe and registered read data. The base value is always aligned to a 1 KB boundary, and its top nibble is hardwired to zero. Only bits 27 down to 10 can be stored.

A separate byte-wide key register guards the base register. The base register comes out of reset locked, and writes to it are dropped while it is locked. Writing the key byte unlocks it. Any accepted base write that enables the most significant byte lane relocks it, after that write has taken effect. Software that uses half-word accesses must therefore write the low half first. A single full-word write updates every writable bit and relocks in one access.

The block also presents the current base address. It presents a vector address as well, formed from a 6-bit trap number. Every access completes in the cycle it is issued. No handshake or back-pressure exists: the strobes are single-cycle pulses that are always accepted.

Top module: `trapbase_reg`

## Requirements
- R1: Base bits [9:0] always read as zero, and writes to them have no effect.
- R2: Base bits [31:28] always read as zero, and writes to them have no effect.
- R3: After reset the base reads 0x00C00000 and the register is locked.
- R4: While locked, every write to the base word (byte address 0x48134, word-aligned) leaves the base unchanged.
- R5: A write to byte address 0x4812D unlocks the register when it carries 0x59. That byte travels in wdata[15:8] of word 0x4812C, with byte enable bit 1 set. Any other value, or the same word without lane 1 enabled, leaves the lock state unchanged.
- R6: An accepted base write with byte enable bit 3 set (bits [31:24]) updates the enabled lanes and then locks the register. A later write is ignored.
- R7: Low half-word (enables 0011) then high half-word (1100) both take effect. High half first locks, so a following low half-word write is ignored.
- R8: An unlocked full-word write (enables 1111) updates all writable bits and relocks in the same access.
- R9: Reading the key word returns zero.
- R10: vec_addr equals base_addr plus four times trap_num, combinationally.
- R11: Read data is valid the cycle after rd_en. Addresses other than the base word read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 20 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables, bit n covers data bits [8n+7:8n] |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, one cycle after rd_en |
| base_addr | output | 32 | Current table base address |
| trap_num | input | 6 | Trap number for vector lookup |
| vec_addr | output | 32 | Vector fetch address |

## Verification
The base write path is driven with three groups of patterns. Full-word and all-ones words separate the fixed-zero fields from the writable field. Half-word pairs are sent in both orders, which shows whether relock happens on the top lane or on every write. Single-lane writes expose per-lane masking. The key path gets the right byte, a wrong byte and the right byte on the wrong lane, which shows whether value and lane are both decoded. Vector addresses are checked at trap numbers 0, 1 and 63, across several base values.

// File: rtl/trapbase_pkg.sv
package trapbase_pkg;
  localparam int DATA_W   = 32;
  localparam int BE_W     = DATA_W / 8;
  localparam int LO_ZERO  = 10;
  localparam int HI_ZERO  = 4;
  localparam int FIELD_W  = DATA_W - LO_ZERO - HI_ZERO;
  localparam int KEY_W    = 8;

  typedef logic [FIELD_W-1:0] field_t;

  function automatic logic [DATA_W-1:0] expand(input field_t f);
    return {{HI_ZERO{1'b0}}, f, {LO_ZERO{1'b0}}};
  endfunction
endpackage

// File: rtl/trapbase_guard.sv
module trapbase_guard #(
  parameter logic [7:0] UNLOCK_KEY = 8'h59
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic [7:0] key_byte,
  input  logic       top_wr,
  output logic       locked
);
  logic locked_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                                locked_q <= 1'b1;
    else if (key_wr && key_byte == UNLOCK_KEY) locked_q <= 1'b0;
    else if (top_wr)                           locked_q <= 1'b1;
  end

  assign locked = locked_q;

  AST_KEY_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr && key_byte == UNLOCK_KEY |=> !locked); // R5
  AST_BAD_KEY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr && key_byte != UNLOCK_KEY && !top_wr |=> locked == $past(locked)); // R5
  AST_TOP_RELOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    top_wr && !key_wr |=> locked); // R6
  AST_OUT_OF_RESET_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> locked); // R3
endmodule

// File: rtl/trapbase_store.sv
module trapbase_store
  import trapbase_pkg::*;
#(
  parameter logic [DATA_W-1:0] RESET_BASE = 32'h00C0_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ok,
  input  logic [BE_W-1:0]   be,
  input  logic [DATA_W-1:0] wdata,
  output field_t            field
);
  localparam field_t RST_FIELD = RESET_BASE[LO_ZERO +: FIELD_W];

  field_t field_q, field_d;

  always_comb begin
    field_d = field_q;
    for (int i = 0; i < FIELD_W; i++) begin
      if (be[(i + LO_ZERO) / 8]) field_d[i] = wdata[i + LO_ZERO];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     field_q <= RST_FIELD;
    else if (wr_ok) field_q <= field_d;
  end

  assign field = field_q;

  AST_LOCKED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ok |=> $stable(field)); // R4
  AST_RESET_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> field == RST_FIELD); // R3
endmodule

// File: rtl/trapbase_vector.sv
module trapbase_vector
  import trapbase_pkg::*;
#(
  parameter int TRAP_W = 6
) (
  input  logic [DATA_W-1:0] base,
  input  logic [TRAP_W-1:0] trap,
  output logic [DATA_W-1:0] vec
);
  localparam int PAD_W = DATA_W - TRAP_W - 2;
  assign vec = base + {{PAD_W{1'b0}}, trap, 2'b00};
endmodule

// File: rtl/trapbase_reg.sv
module trapbase_reg
  import trapbase_pkg::*;
#(
  parameter int          ADDR_W     = 20,
  parameter int          TRAP_W     = 6,
  parameter logic [19:0] BASE_ADDR  = 20'h48134,
  parameter logic [19:0] KEY_ADDR   = 20'h4812D,
  parameter logic [7:0]  UNLOCK_KEY = 8'h59
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [3:0]        bus_be,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [31:0]       bus_rdata,
  output logic [31:0]       base_addr,
  input  logic [TRAP_W-1:0] trap_num,
  output logic [31:0]       vec_addr
);
  localparam int KEY_LANE = int'(KEY_ADDR[1:0]);
  localparam int TOP_LANE = BE_W - 1;

  logic   base_sel, key_sel, locked, wr_ok, key_wr, top_wr;
  field_t field;
  logic [31:0] rdata_q;

  assign base_sel = bus_addr[ADDR_W-1:2] == BASE_ADDR[ADDR_W-1:2];
  assign key_sel  = bus_addr[ADDR_W-1:2] == KEY_ADDR[ADDR_W-1:2];
  assign wr_ok    = wr_en && base_sel && !locked;
  assign key_wr   = wr_en && key_sel && bus_be[KEY_LANE];
  assign top_wr   = wr_ok && bus_be[TOP_LANE];

  trapbase_guard #(.UNLOCK_KEY(UNLOCK_KEY)) u_guard (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr),
    .key_byte(bus_wdata[KEY_LANE*8 +: 8]), .top_wr(top_wr), .locked(locked)
  );

  trapbase_store u_store (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .be(bus_be),
    .wdata(bus_wdata), .field(field)
  );

  assign base_addr = expand(field);

  trapbase_vector #(.TRAP_W(TRAP_W)) u_vec (
    .base(base_addr), .trap(trap_num), .vec(vec_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                rdata_q <= '0;
    else if (rd_en && base_sel) rdata_q <= base_addr;
    else if (rd_en)            rdata_q <= '0;
  end

  assign bus_rdata = rdata_q;

  AST_LOW_FIELD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    base_addr[LO_ZERO-1:0] == '0 && bus_rdata[LO_ZERO-1:0] == '0); // R1
  AST_HIGH_FIELD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    base_addr[31 -: HI_ZERO] == '0 && bus_rdata[31 -: HI_ZERO] == '0); // R2
  AST_OTHER_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !base_sel |=> bus_rdata == '0); // R11
  AST_KEY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && key_sel |=> bus_rdata == '0); // R9
endmodule

// File: tb/trapbase_reg_test.sv
`timescale 1ns/1ps
module trapbase_reg_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [19:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic        wr_en = 0, rd_en = 0;
  logic [31:0] bus_rdata, base_addr, vec_addr;
  logic [5:0]  trap_num = '0;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] m_base = 32'h00C0_0000;
  logic        m_lock = 1;
  bit          done = 0;

  localparam logic [19:0] A_BASE = 20'h48134;
  localparam logic [19:0] A_KEY  = 20'h4812C;

  trapbase_reg uut (.*);

  always #4 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [19:0] a, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_be = be; wr_en = 1;
    if (a == A_KEY && be[1]) begin
      if (d[15:8] == 8'h59) m_lock = 0;
    end else if (a == A_BASE && !m_lock) begin
      for (int i = 10; i < 28; i++) if (be[i/8]) m_base[i] = d[i];
      if (be[3]) m_lock = 1;
    end
    @(negedge clk);
    wr_en = 0; bus_be = '0;
  endtask

  task automatic do_read(logic [19:0] a, string req);
    @(negedge clk);
    exp_q.push_back(a == A_BASE ? m_base : 32'h0);
    tag_q.push_back(req);
    bus_addr = a; rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    @(negedge clk);
  endtask

  task automatic check_vec(logic [5:0] t, string req);
    @(negedge clk);
    trap_num = t;
    #1 check(req, vec_addr, m_base + {24'h0, t, 2'b00});
  endtask

  // monitor: pops one expected item for each read accepted at a clock edge
  always @(posedge clk) begin
    logic took;
    took = rd_en && rst_n;
    #2;
    if (took) begin
      string t;
      logic [31:0] e;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, bus_rdata, e);
    end
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1 check("R3 reset base", base_addr, 32'h00C0_0000);
    do_read(A_BASE, "R3 reset read");
    check_vec(6'd0, "R10 trap0");
    do_write(A_BASE, 32'hFFFF_FFFF, 4'hF);
    do_read(A_BASE, "R4 locked write ignored");
    do_write(A_KEY, 32'h0000_5800, 4'h2);
    do_write(A_BASE, 32'hFFFF_FFFF, 4'hF);
    do_read(A_BASE, "R5 wrong key keeps lock");
    do_write(A_KEY, 32'h0000_5900, 4'h2);
    do_read(A_KEY, "R9 key reads zero");
    do_write(A_BASE, 32'hFFFF_FFFF, 4'h3);
    do_read(A_BASE, "R1 R7 low half");
    check("R1 low bits", base_addr, 32'h00C0_FC00);
    do_write(A_BASE, 32'hABCD_1234, 4'hC);
    do_read(A_BASE, "R2 R7 high half");
    check("R2 top nibble", base_addr, 32'h0BCD_FC00);
    do_write(A_BASE, 32'h0000_0000, 4'h3);
    do_read(A_BASE, "R6 relocked after top lane");
    do_write(A_KEY, 32'h0000_5900, 4'h2);
    do_write(A_BASE, 32'h0123_0000, 4'hC);
    do_write(A_BASE, 32'h0000_0000, 4'h3);
    do_read(A_BASE, "R7 high first locks");
    check("R7 high first base", base_addr, 32'h0123_FC00);
    do_write(A_KEY, 32'h0000_5900, 4'h2);
    do_write(A_BASE, 32'h5555_5555, 4'hF);
    do_write(A_BASE, 32'h0000_0000, 4'hF);
    do_read(A_BASE, "R8 full word relocks");
    check("R8 full word base", base_addr, 32'h0555_5400);
    check_vec(6'd1, "R10 trap1");
    do_write(A_KEY, 32'h0000_5900, 4'h2);
    do_write(A_BASE, 32'h0077_0000, 4'h4);
    do_write(A_BASE, 32'h0000_0000, 4'h2);
    check("R6 lane writes no relock", base_addr, 32'h0577_0000);
    do_write(A_BASE, 32'h0000_0000, 4'h8);
    do_write(A_KEY, 32'h0000_0059, 4'h1);
    do_write(A_BASE, 32'hFFFF_FFFF, 4'hF);
    do_read(A_BASE, "R5 key on wrong lane");
    check("R5 wrong lane base", base_addr, 32'h0077_0000);
    check_vec(6'd63, "R10 trap63");
    do_read(20'h48000, "R11 unmapped reads zero");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule